// File: doc/BRIEF.md
# Optical Black Level Averager

This block turns a stream of digitized optical-black pixels into a smoothed black-level estimate for an offset calibration loop. On every line a window enable marks the shielded pixels. The block counts a programmable number of them and sums them. While it sums, it can replace defective pixels that lie far from a target code. When the count is reached it divides the sum to get a line average. It then moves a running estimate toward that average by a power-of-two fraction.

A start-of-frame request makes the next line stand on its own. That line uses full weight and skips the defect filter, so the estimate snaps to the new level after an exposure or gain change. The request can come from a direct pulse, or from a gain-jump pulse when the automatic option is on. A clear pulse empties the estimate. A test input adds a fixed offset of 255 to every pixel.

Top module: `ob_black_avg`

## Requirements
- R1: A line completes after L accepted pixels, where L = 2^min(N,6) for the 3-bit exponent N, and L is tripled when the multiplier input is 1 (so L is one of 1..64 or 3..192). A pixel is accepted only in a cycle where both the window enable and pixel valid are high. Pixels after the L-th in the same window are ignored. A window that closes before L pixels leaves the outputs unchanged, and counting restarts when the window opens again.
- R2: The line average is floor(sum of the L accepted pixel values / L), and it is exact for every L, including the tripled counts.
- R3: When the test-offset input is 1, every pixel value is increased by 255 before the defect filter and before the sum, so averages up to 1278 appear.
- R4: When the defect-bypass input is 0, an accepted pixel is replaced if its value lies outside [target-8, target+8] (bounds included). It is replaced by the previous accepted pixel of the line, taken after its own replacement. For the first pixel of a line it is replaced by the last completed line average, which is 0 after reset or clear.
- R5: When the defect-bypass input is 1, pixel values reach the sum unchanged.
- R6: On each completed line the estimate y, which has 8 fractional bits, becomes y + floor((avg*256 - y) / 2^k). Here k equals the weight code for codes 0..8, and codes 9..15 behave as code 8.
- R7: A start-of-frame request applies to the first line that starts in a later cycle. That line uses k = 0 and no defect replacement. The lines after it return to the programmed weight and filter setting.
- R8: A gain-jump pulse acts as a start-of-frame request when the auto option input is 1, and has no effect when it is 0.
- R9: A clear pulse sets the estimate and the last line average to 0 on the next edge. It drops the partial line, so counting restarts, and it raises no valid strobe.
- R10: If the last pixel of a line is sampled at edge k, the new estimate and line average appear, and the valid strobe is high, from edge k+1 until edge k+2. At all other times the outputs hold.
- R11: After reset the estimate, the line average and the valid strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_i | input | 10 | Digitized pixel code |
| pix_vld_i | input | 1 | Pixel code valid this cycle |
| win_en_i | input | 1 | Optical-black window enable |
| cnt_exp_i | input | 3 | Pixel-count exponent N |
| cnt_x3_i | input | 1 | Triple the pixel count |
| wt_code_i | input | 4 | Blend weight code k |
| defect_byp_i | input | 1 | 1 disables defect replacement |
| target_i | input | 10 | Centre code of the defect band |
| bias_test_i | input | 1 | Add 255 to each pixel |
| sof_req_i | input | 1 | Start-of-frame request pulse |
| auto_sof_en_i | input | 1 | Let gain jumps request start of frame |
| gain_jump_i | input | 1 | Large gain change pulse |
| avg_clr_i | input | 1 | Clear the estimate |
| est_o | output | 19 | Black-level estimate, 11 integer and 8 fractional bits |
| line_avg_o | output | 11 | Last completed line average |
| est_vld_o | output | 1 | One-cycle strobe on each update |

## Verification
The bench targets the division for tripled counts at 192 pixels with values near full scale. A reciprocal that is too short would drop the average by one code there. It targets the first pixel of a line when that pixel is out of band, where a design that seeds from the stale previous pixel instead of the last average would diverge. It also targets a start-of-frame request that arrives mid-line; a design that applies it at once would blend that line at full weight. Finally it targets weight codes above 8, a clear that lands inside an open window, and pixels beyond the count limit, which a design that keeps counting would fold into the sum.

// File: rtl/obavg_pkg.sv
package obavg_pkg;
  localparam int PIX_W   = 10;
  localparam int EXT_W   = PIX_W + 1;
  localparam int FRAC_W  = 8;
  localparam int MAX_EXP = 6;
  localparam int LEN_W   = 8;
  localparam int MAX_LEN = 3 << MAX_EXP;
  localparam int ACC_W   = EXT_W + LEN_W;
  localparam int EST_W   = EXT_W + FRAC_W;
  localparam int MAX_SH  = 8;
  localparam int RCP_S   = ACC_W + 1;
  localparam logic [RCP_S-1:0] RCP3 = RCP_S'(((64'd1 << RCP_S) + 64'd2) / 64'd3);

  // exponent limited to the largest supported window
  function automatic logic [2:0] exp_clamp(input logic [2:0] n);
    return (n > 3'(MAX_EXP)) ? 3'(MAX_EXP) : n;
  endfunction

  function automatic logic [LEN_W-1:0] win_len(input logic [2:0] n, input logic x3);
    logic [LEN_W-1:0] b;
    b = LEN_W'(1) << exp_clamp(n);
    return x3 ? LEN_W'({1'b0, b} + {b, 1'b0}) : b;
  endfunction

  function automatic logic band_ok(input logic [EXT_W-1:0] p, input logic [PIX_W-1:0] t,
                                   input int lim);
    int pi;
    int ti;
    pi = int'(p);
    ti = int'(t);
    return (pi >= ti - lim) && (pi <= ti + lim);
  endfunction

  // divide by 3 through a reciprocal, then by the power of two
  function automatic logic [EXT_W-1:0] line_mean(input logic [ACC_W-1:0] acc,
                                                 input logic [2:0] n, input logic x3);
    logic [ACC_W+RCP_S-1:0] prod;
    logic [ACC_W-1:0] q;
    prod = (ACC_W+RCP_S)'(acc) * (ACC_W+RCP_S)'(RCP3);
    q = x3 ? ACC_W'(prod >> RCP_S) : acc;
    q = q >> exp_clamp(n);
    return EXT_W'(q);
  endfunction

  function automatic logic [3:0] wt_shift(input logic [3:0] code);
    return (code > 4'(MAX_SH)) ? 4'(MAX_SH) : code;
  endfunction

  function automatic logic [EST_W-1:0] blend(input logic [EST_W-1:0] y,
                                             input logic [EXT_W-1:0] avg,
                                             input logic [3:0] sh);
    logic signed [EST_W+1:0] d;
    logic signed [EST_W+1:0] s;
    d = $signed({2'b00, avg, {FRAC_W{1'b0}}}) - $signed({2'b00, y});
    s = d >>> sh;
    return EST_W'($signed({2'b00, y}) + s);
  endfunction
endpackage

// File: rtl/ob_defect_filter.sv
module ob_defect_filter
  import obavg_pkg::*;
#(
  parameter int LIM  = 8,
  parameter int BIAS = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             bias_en,
  input  logic [PIX_W-1:0] target,
  input  logic             filt_on,
  input  logic             take,
  input  logic             first,
  input  logic [EXT_W-1:0] seed,
  output logic [EXT_W-1:0] pix_o,
  output logic             repl_o
);
  logic [EXT_W-1:0] pix_e;
  logic [EXT_W-1:0] prev_q;

  assign pix_e  = EXT_W'(pix_i) + (bias_en ? EXT_W'(BIAS) : '0);
  assign repl_o = filt_on && !band_ok(pix_e, target, LIM);
  assign pix_o  = repl_o ? (first ? seed : prev_q) : pix_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_q <= '0;
    else if (clr)    prev_q <= '0;
    else if (take)   prev_q <= pix_o;
  end
endmodule

// File: rtl/ob_line_accum.sv
module ob_line_accum
  import obavg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             win_en,
  input  logic             pix_vld,
  input  logic [2:0]       n_sel,
  input  logic             x3,
  input  logic [EXT_W-1:0] pix_f,
  output logic             take_o,
  output logic             first_o,
  output logic             done_o,
  output logic [EXT_W-1:0] avg_o
);
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q;
  logic             done_q;

  assign len     = win_len(n_sel, x3);
  assign take_o  = pix_vld && win_en && (cnt_q < len) && !clr;
  assign first_o = (cnt_q == '0);
  assign done_o  = done_q;
  assign avg_o   = line_mean(acc_q, n_sel, x3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= take_o && (cnt_q == len - 1'b1);
      if (clr || !win_en) begin
        cnt_q <= '0;
        acc_q <= '0;
      end else if (take_o) begin
        cnt_q <= cnt_q + 1'b1;
        acc_q <= acc_q + ACC_W'(pix_f);
      end
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LEN_W'(MAX_LEN)); // R1
endmodule

// File: rtl/ob_iir_blend.sv
module ob_iir_blend
  import obavg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic [EXT_W-1:0] avg,
  input  logic [3:0]       sh,
  output logic [EST_W-1:0] est_o,
  output logic [EXT_W-1:0] line_o,
  output logic             vld_o
);
  logic [EST_W-1:0] est_q;
  logic [EXT_W-1:0] line_q;
  logic             vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_q  <= '0;
      line_q <= '0;
      vld_q  <= 1'b0;
    end else if (clr) begin
      est_q  <= '0;
      line_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= upd;
      if (upd) begin
        est_q  <= blend(est_q, avg, sh);
        line_q <= avg;
      end
    end
  end

  assign est_o  = est_q;
  assign line_o = line_q;
  assign vld_o  = vld_q;

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (est_q == '0 && line_q == '0 && !vld_q)); // R9
  AST_FULL_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr && sh == 4'd0) |=> est_q == {$past(avg), {FRAC_W{1'b0}}}); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clr) |=> $stable(est_q) && $stable(line_q)); // R10
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q); // R10
endmodule

// File: rtl/ob_black_avg.sv
module ob_black_avg
  import obavg_pkg::*;
#(
  parameter int LIM  = 8,
  parameter int BIAS = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pix_vld_i,
  input  logic             win_en_i,
  input  logic [2:0]       cnt_exp_i,
  input  logic             cnt_x3_i,
  input  logic [3:0]       wt_code_i,
  input  logic             defect_byp_i,
  input  logic [PIX_W-1:0] target_i,
  input  logic             bias_test_i,
  input  logic             sof_req_i,
  input  logic             auto_sof_en_i,
  input  logic             gain_jump_i,
  input  logic             avg_clr_i,
  output logic [EST_W-1:0] est_o,
  output logic [EXT_W-1:0] line_avg_o,
  output logic             est_vld_o
);
  logic             take;
  logic             first;
  logic             line_done;
  logic             repl;
  logic             cur_sof;
  logic             sof_req;
  logic             line_start;
  logic             filt_on;
  logic             sof_pend_q;
  logic             sof_line_q;
  logic [3:0]       sh;
  logic [EXT_W-1:0] pix_f;
  logic [EXT_W-1:0] avg;

  assign sof_req    = sof_req_i || (auto_sof_en_i && gain_jump_i);
  assign line_start = take && first;
  assign cur_sof    = first ? sof_pend_q : sof_line_q;
  assign filt_on    = !defect_byp_i && !cur_sof;
  assign sh         = sof_line_q ? 4'd0 : wt_shift(wt_code_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_pend_q <= 1'b0;
      sof_line_q <= 1'b0;
    end else begin
      sof_pend_q <= line_start ? sof_req : (sof_pend_q || sof_req);
      if (avg_clr_i)       sof_line_q <= 1'b0;
      else if (line_start) sof_line_q <= sof_pend_q;
      else if (line_done)  sof_line_q <= 1'b0;
    end
  end

  ob_defect_filter #(.LIM(LIM), .BIAS(BIAS)) u_filt (
    .clk(clk), .rst_n(rst_n), .clr(avg_clr_i), .pix_i(pix_i),
    .bias_en(bias_test_i), .target(target_i), .filt_on(filt_on),
    .take(take), .first(first), .seed(line_avg_o),
    .pix_o(pix_f), .repl_o(repl)
  );

  ob_line_accum u_acc (
    .clk(clk), .rst_n(rst_n), .clr(avg_clr_i), .win_en(win_en_i),
    .pix_vld(pix_vld_i), .n_sel(cnt_exp_i), .x3(cnt_x3_i), .pix_f(pix_f),
    .take_o(take), .first_o(first), .done_o(line_done), .avg_o(avg)
  );

  ob_iir_blend u_blend (
    .clk(clk), .rst_n(rst_n), .clr(avg_clr_i), .upd(line_done),
    .avg(avg), .sh(sh), .est_o(est_o), .line_o(line_avg_o), .vld_o(est_vld_o)
  );

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && defect_byp_i && !bias_test_i) |-> pix_f == {1'b0, pix_i}); // R5
  AST_SOF_NO_REPL: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sof_line_q) |-> !repl); // R7
  AST_DONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && !avg_clr_i) |=> est_vld_o); // R10
endmodule

// File: tb/sim_ob_black_avg.sv
module sim_ob_black_avg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] pix = '0;
  logic pvld = 1'b0, win = 1'b0, x3 = 1'b0, byp = 1'b1, bias = 1'b0;
  logic sreq = 1'b0, aen = 1'b0, gj = 1'b0, clr = 1'b0;
  logic [2:0] nexp = 3'd3;
  logic [3:0] wt = 4'd7;
  logic [9:0] tgt = 10'd64;
  wire [18:0] est;
  wire [10:0] lavg;
  wire evld;

  always #2 clk = ~clk;

  ob_black_avg u0 (
    .clk(clk), .rst_n(rst_n), .pix_i(pix), .pix_vld_i(pvld), .win_en_i(win),
    .cnt_exp_i(nexp), .cnt_x3_i(x3), .wt_code_i(wt), .defect_byp_i(byp),
    .target_i(tgt), .bias_test_i(bias), .sof_req_i(sreq), .auto_sof_en_i(aen),
    .gain_jump_i(gj), .avg_clr_i(clr), .est_o(est), .line_avg_o(lavg), .est_vld_o(evld)
  );

  int checks = 0, errors = 0, pulses = 0, cyc = 0;
  string cur_req = "R11";
  bit finished = 0;

  // behavioural reference model
  int m_cnt = 0, m_acc = 0, m_prev = 0, m_last = 0, m_y = 0;
  bit m_vld = 0, m_done = 0, m_pend = 0, m_sofl = 0;
  int len, pe, avg, sh, n_y, n_last;
  bit take, first, cur_sof, req, n_sofl, n_done;

  always @(posedge clk) begin
    len = (1 << ((nexp > 6) ? 6 : nexp)) * (x3 ? 3 : 1);
    req = sreq || (aen && gj);
    if (!rst_n) begin
      m_cnt = 0; m_acc = 0; m_prev = 0; m_last = 0; m_y = 0;
      m_vld = 0; m_done = 0; m_pend = 0; m_sofl = 0;
    end else if (clr) begin
      m_cnt = 0; m_acc = 0; m_prev = 0; m_last = 0; m_y = 0;
      m_vld = 0; m_done = 0; m_sofl = 0; m_pend = m_pend || req;
    end else begin
      n_y = m_y; n_last = m_last; n_sofl = m_sofl;
      if (m_done) begin
        avg = m_acc / len;
        sh = m_sofl ? 0 : ((wt > 8) ? 8 : int'(wt));
        n_y = m_y + ((avg * 256 - m_y) >>> sh);
        n_last = avg;
        n_sofl = 0;
      end
      take = pvld && win && (m_cnt < len);
      first = (m_cnt == 0);
      cur_sof = first ? m_pend : m_sofl;
      pe = int'(pix) + (bias ? 255 : 0);
      if (take && !byp && !cur_sof && (pe < int'(tgt) - 8 || pe > int'(tgt) + 8))
        pe = first ? m_last : m_prev;
      n_done = take && (m_cnt == len - 1);
      if (!win) begin m_cnt = 0; m_acc = 0; end
      else if (take) begin m_cnt = m_cnt + 1; m_acc = m_acc + pe; m_prev = pe; end
      if (take && first) begin n_sofl = m_pend; m_pend = req; end
      else m_pend = m_pend || req;
      m_vld = m_done; m_done = n_done;
      m_y = n_y; m_last = n_last; m_sofl = n_sofl;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (est !== 19'(m_y) || lavg !== 11'(m_last) || evld !== m_vld) begin
        errors++;
        $display("FAIL %s est=%0d exp=%0d line=%0d exp=%0d vld=%0d exp=%0d",
                 cur_req, est, m_y, lavg, m_last, evld, m_vld);
      end
      if (evld === 1'b1) pulses++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog %s expired", cur_req);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string r, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", r, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pvld = 0; win = 0; sreq = 0; gj = 0; clr = 0;
    end
  endtask

  task automatic run_line(input int n, input int base, input int step, input int outl,
                          input int gap, input int req_at, input int clr_at);
    for (int i = 0; i < n; i++) begin
      int v;
      @(negedge clk);
      win = 1; gj = 0;
      sreq = (i == req_at);
      clr = (i == clr_at);
      pvld = !(gap > 0 && (i % gap) == gap - 1);
      v = base + (i * step) % 13;
      if (outl > 0 && (i % outl) == 0) v = v + 300;
      pix = 10'(v % 1024);
    end
    idle(4);
  endtask

  initial begin
    int p0;
    idle(3);
    chk("R11", int'(est), 0); chk("R11", int'(lavg), 0); chk("R11", int'(evld), 0);
    rst_n = 1;
    idle(2);

    cur_req = "R2"; nexp = 3; x3 = 0; wt = 0; byp = 1;
    p0 = pulses;
    run_line(8, 200, 0, 0, 0, -1, -1);
    chk("R2", int'(lavg), 200); chk("R6", int'(est), 51200); chk("R10", pulses - p0, 1);
    run_line(12, 100, 5, 0, 3, -1, -1);
    chk("R1", pulses - p0, 2);

    cur_req = "R1";
    run_line(20, 300, 7, 0, 0, -1, -1);
    nexp = 7; run_line(70, 400, 0, 0, 0, -1, -1);
    chk("R1", int'(lavg), 400);
    nexp = 0; run_line(1, 77, 0, 0, 0, -1, -1);
    chk("R1", int'(lavg), 77);

    cur_req = "R10";
    @(negedge clk); win = 1; pvld = 1; pix = 10'd55;
    @(negedge clk); pvld = 0;
    chk("R10", int'(evld), 0);
    @(negedge clk); chk("R10", int'(evld), 1); chk("R10", int'(lavg), 55);
    @(negedge clk); chk("R10", int'(evld), 0);
    idle(2);

    cur_req = "R2";
    nexp = 2; x3 = 1; run_line(12, 500, 11, 0, 0, -1, -1);
    nexp = 1; run_line(6, 10, 1, 0, 0, -1, -1);
    chk("R2", int'(lavg), 12);
    nexp = 6; run_line(200, 1005, 1, 0, 0, -1, -1);
    x3 = 0;

    cur_req = "R1";
    nexp = 4; p0 = pulses;
    run_line(10, 300, 2, 0, 0, -1, -1);
    chk("R1", pulses - p0, 0);

    cur_req = "R6";
    nexp = 3;
    wt = 7; for (int i = 0; i < 3; i++) run_line(8, 150 + 40 * i, 3, 0, 0, -1, -1);
    wt = 1; run_line(8, 700, 5, 0, 0, -1, -1);
    wt = 3; run_line(8, 20, 9, 0, 2, -1, -1);
    wt = 12; run_line(8, 333, 4, 0, 0, -1, -1);

    cur_req = "R3";
    wt = 0; bias = 1; nexp = 2;
    run_line(4, 1000, 0, 0, 0, -1, -1);
    chk("R3", int'(lavg), 1255);
    bias = 0;

    cur_req = "R4";
    byp = 0; tgt = 64; wt = 3; nexp = 3;
    for (int i = 0; i < 3; i++) run_line(8, 60, 1, 3, 0, -1, -1);
    run_line(12, 58, 2, 4, 3, -1, -1);

    cur_req = "R5";
    byp = 1; wt = 0; nexp = 2;
    run_line(4, 60, 0, 2, 0, -1, -1);
    chk("R5", int'(lavg), 210);

    cur_req = "R7";
    byp = 0; wt = 7;
    @(negedge clk); sreq = 1;
    idle(2);
    run_line(4, 60, 0, 2, 0, -1, -1);
    chk("R7", int'(lavg), 210); chk("R7", int'(est), 53760);
    run_line(4, 60, 0, 2, 0, -1, -1);
    nexp = 3;
    run_line(8, 62, 1, 3, 0, 3, -1);
    run_line(8, 62, 1, 3, 0, -1, -1);
    run_line(8, 62, 1, 3, 0, -1, -1);

    cur_req = "R8";
    aen = 0;
    @(negedge clk); gj = 1;
    idle(2);
    run_line(8, 400, 0, 0, 0, -1, -1);
    chk("R8", int'(est == 19'(400 * 256)), 0);
    aen = 1;
    @(negedge clk); gj = 1;
    idle(2);
    run_line(8, 400, 0, 0, 0, -1, -1);
    chk("R8", int'(est), 400 * 256);
    aen = 0;

    cur_req = "R9";
    p0 = pulses;
    run_line(12, 90, 2, 0, 0, -1, 5);
    chk("R9", int'(est), 0); chk("R9", int'(lavg), 0); chk("R9", pulses - p0, 0);

    cur_req = "R6";
    byp = 1; wt = 15; nexp = 2;
    run_line(4, 256, 0, 0, 0, -1, -1);
    chk("R6", int'(est), 256);
    run_line(4, 512, 0, 0, 0, -1, -1);
    chk("R6", int'(est), 256 + 511);

    idle(4);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule